// File: doc/BRIEF.md
# Pin-Clocked Frequency Divider Channel

This block is a single timer channel that divides the frequency of a signal arriving on an external pin. The raw pin passes through a two-flop synchronizer. An edge detector then picks out falling edges, rising edges or both, as the edge-select field chooses. Each valid edge decrements a 16-bit counter. The counter starts at a software-supplied reload value N. When a valid edge arrives while the count is zero, the counter reloads N, the interrupt line pulses for one clock, and the output toggles. The output therefore has a period of 2×(N+1) valid edges.

Counting starts only on a software start strobe and halts on a stop strobe. Stopping freezes the output at its current level. An optional start-behaviour bit makes the start itself raise the interrupt and invert the output. An output-enable bit decides what drives the output. When the bit is high, the counting logic drives the output. When it is low, counting leaves the output alone and software can force the level through a direct write port.

Top module: `pin_freq_div`

## Requirements
- R1: While `rst` is high at a clock edge, the next state has `tout_o` = 0, `irq_o` = 0 and the channel stopped, so pin edges are not counted until a start.
- R2: `edge_sel_i` selects the valid edge: 2'b00 counts falling edges, 2'b01 rising edges and 2'b10 both edges of the synchronized pin. A pin level that is first sampled at clock edge k is counted at clock edge k+2, and any resulting interrupt is visible on `irq_o` after that edge.
- R3: While `edge_sel_i` = 2'b11, no edge is counted, no expiry interrupt occurs and counting leaves `tout_o` unchanged.
- R4: A start loads N from `reload_i`. Each valid edge while running decrements the count. A valid edge at count 0 reloads N and makes `irq_o` high for exactly the following clock, so one pulse occurs per N+1 valid edges.
- R5: With `out_en_i` = 1, each expiry inverts `tout_o` on the same clock edge as the interrupt, giving an output period of 2×(N+1) valid edges.
- R6: On a cycle with `start_i` high and `start_irq_i` = 1, the next cycle has `irq_o` = 1, and `tout_o` is inverted if `out_en_i` = 1. With `start_irq_i` = 0, starting produces neither effect.
- R7: `stop_i` halts counting. While stopped, pin edges raise no interrupt and `tout_o` holds. A later start reloads N.
- R8: With `out_en_i` = 0, counting and starts do not change `tout_o`. A cycle with `out_wr_i` high sets `tout_o` to `out_val_i` on the next cycle. With `out_en_i` = 1, `out_wr_i` is ignored.
- R9: If `start_i` and `stop_i` are high in the same cycle, the start wins and the channel runs. A valid edge in the same cycle as a start is not counted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| tin_i | input | 1 | Raw, asynchronous timer input pin |
| start_i | input | 1 | Software start strobe (one clock) |
| stop_i | input | 1 | Software stop strobe (one clock) |
| reload_i | input | 16 | Reload value N |
| edge_sel_i | input | 2 | 00 falling, 01 rising, 10 both, 11 none |
| start_irq_i | input | 1 | 1: start raises interrupt and toggles output |
| out_en_i | input | 1 | 1: counting drives the output |
| out_wr_i | input | 1 | Direct output write strobe (honoured when out_en_i = 0) |
| out_val_i | input | 1 | Level written by out_wr_i |
| tout_o | output | 1 | Divided toggle output |
| irq_o | output | 1 | One-clock interrupt pulse |

## Verification
The bench goes after off-by-one reload handling. A design that expires at count 1, or reloads N-1, would give the wrong number of interrupts per burst of edges and an output period other than 2×(N+1). It also checks the prohibited edge code, falling-only mode and both-edge mode. A detector that treats 11 as both edges, or that mixes up polarities, shows up as stray or missing pulses. Separate checks cover the start-with-interrupt option, simultaneous start and stop, edges arriving while stopped, and the output-enable gating. A design that lets counting move the output while it is disabled, or that honours direct writes while it is enabled, would diverge from the cycle-by-cycle model at once.

// File: rtl/pin_freq_div_pkg.sv
package pin_freq_div_pkg;

    localparam int CNT_W_DEF = 16;

    typedef enum logic [1:0] {
        EDGE_FALL = 2'b00,
        EDGE_RISE = 2'b01,
        EDGE_BOTH = 2'b10,
        EDGE_NONE = 2'b11
    } edge_mode_e;

    typedef struct packed {
        logic expire;
        logic start_evt;
    } cnt_evt_t;

    function automatic logic edge_hit(edge_mode_e mode, logic cur, logic prev);
        logic hit;
        unique case (mode)
            EDGE_FALL: hit = prev & ~cur;
            EDGE_RISE: hit = cur & ~prev;
            EDGE_BOTH: hit = cur ^ prev;
            default:   hit = 1'b0;
        endcase
        return hit;
    endfunction

endpackage

// File: rtl/pin_freq_div_edge.sv
module pin_freq_div_edge
    import pin_freq_div_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       pin_i,
    input  edge_mode_e mode_i,
    output logic       edge_o
);
    localparam int LAST = SYNC_STAGES - 1;

    logic [SYNC_STAGES-1:0] chain_q;
    logic                   prev_q;

    generate
        if (SYNC_STAGES == 1) begin : g_single
            always_ff @(posedge clk) begin
                if (rst) chain_q <= '0;
                else     chain_q <= pin_i;
            end
        end else begin : g_multi
            always_ff @(posedge clk) begin
                if (rst) chain_q <= '0;
                else     chain_q <= {chain_q[SYNC_STAGES-2:0], pin_i};
            end
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (rst) prev_q <= 1'b0;
        else     prev_q <= chain_q[LAST];
    end

    assign edge_o = edge_hit(mode_i, chain_q[LAST], prev_q);

    // R3
    edge_none_chk: assert property (@(posedge clk) disable iff (rst)
        (mode_i == EDGE_NONE) |-> !edge_o);

endmodule

// File: rtl/pin_freq_div_cnt.sv
module pin_freq_div_cnt
    import pin_freq_div_pkg::*;
#(
    parameter int CNT_W = CNT_W_DEF
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             start_i,
    input  logic             stop_i,
    input  logic             start_irq_i,
    input  logic             edge_i,
    input  logic [CNT_W-1:0] reload_i,
    output cnt_evt_t         evt_o
);
    logic             running_q;
    logic [CNT_W-1:0] cnt_q;
    logic             at_zero;

    assign at_zero          = (cnt_q == '0);
    assign evt_o.start_evt  = start_i & start_irq_i;
    assign evt_o.expire     = !start_i && !stop_i && running_q && edge_i && at_zero;

    always_ff @(posedge clk) begin
        if (rst) begin
            running_q <= 1'b0;
            cnt_q     <= '0;
        end else if (start_i) begin
            running_q <= 1'b1;
            cnt_q     <= reload_i;
        end else if (stop_i) begin
            running_q <= 1'b0;
        end else if (running_q && edge_i) begin
            if (at_zero) cnt_q <= reload_i;
            else         cnt_q <= cnt_q - 1'b1;
        end
    end

    // R9
    start_wins_chk: assert property (@(posedge clk) disable iff (rst)
        (start_i && stop_i) |=> running_q);

    // R7
    idle_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        (!running_q && !start_i) |-> !evt_o.expire);

    // R4
    hold_count_chk: assert property (@(posedge clk) disable iff (rst)
        (!start_i && !edge_i) |=> $stable(cnt_q));

endmodule

// File: rtl/pin_freq_div_out.sv
module pin_freq_div_out
    import pin_freq_div_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  cnt_evt_t evt_i,
    input  logic     out_en_i,
    input  logic     out_wr_i,
    input  logic     out_val_i,
    output logic     tout_o,
    output logic     irq_o
);
    logic tout_q;
    logic irq_q;
    logic flip;

    assign flip = evt_i.expire | evt_i.start_evt;

    always_ff @(posedge clk) begin
        if (rst) begin
            tout_q <= 1'b0;
            irq_q  <= 1'b0;
        end else begin
            irq_q <= flip;
            if (out_en_i) begin
                if (flip) tout_q <= ~tout_q;
            end else if (out_wr_i) begin
                tout_q <= out_val_i;
            end
        end
    end

    assign tout_o = tout_q;
    assign irq_o  = irq_q;

    // R8
    gated_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (!out_en_i && !out_wr_i) |=> $stable(tout_q));

    // R8
    direct_write_chk: assert property (@(posedge clk) disable iff (rst)
        (!out_en_i && out_wr_i) |=> (tout_q == $past(out_val_i)));

    // R5
    toggle_on_irq_chk: assert property (@(posedge clk) disable iff (rst)
        (out_en_i && flip) |=> (tout_q != $past(tout_q)));

    // R1
    reset_clear_chk: assert property (@(posedge clk)
        rst |=> (!tout_q && !irq_q));

endmodule

// File: rtl/pin_freq_div.sv
module pin_freq_div
    import pin_freq_div_pkg::*;
#(
    parameter int CNT_W       = CNT_W_DEF,
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             tin_i,
    input  logic             start_i,
    input  logic             stop_i,
    input  logic [CNT_W-1:0] reload_i,
    input  logic [1:0]       edge_sel_i,
    input  logic             start_irq_i,
    input  logic             out_en_i,
    input  logic             out_wr_i,
    input  logic             out_val_i,
    output logic             tout_o,
    output logic             irq_o
);
    edge_mode_e mode;
    logic       edge_v;
    cnt_evt_t   evt;

    assign mode = edge_mode_e'(edge_sel_i);

    pin_freq_div_edge #(.SYNC_STAGES(SYNC_STAGES)) u_edge (
        .clk    (clk),
        .rst    (rst),
        .pin_i  (tin_i),
        .mode_i (mode),
        .edge_o (edge_v)
    );

    pin_freq_div_cnt #(.CNT_W(CNT_W)) u_cnt (
        .clk         (clk),
        .rst         (rst),
        .start_i     (start_i),
        .stop_i      (stop_i),
        .start_irq_i (start_irq_i),
        .edge_i      (edge_v),
        .reload_i    (reload_i),
        .evt_o       (evt)
    );

    pin_freq_div_out u_out (
        .clk       (clk),
        .rst       (rst),
        .evt_i     (evt),
        .out_en_i  (out_en_i),
        .out_wr_i  (out_wr_i),
        .out_val_i (out_val_i),
        .tout_o    (tout_o),
        .irq_o     (irq_o)
    );

    // R3
    no_edge_irq_chk: assert property (@(posedge clk) disable iff (rst)
        (edge_sel_i == 2'b11 && !start_i) |=> !irq_o);

endmodule

// File: tb/pin_freq_div_tb.sv
`timescale 1ns/1ps
module pin_freq_div_tb;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        tin = 1'b0;
    logic        start = 1'b0, stop = 1'b0;
    logic [15:0] reload = 16'd0;
    logic [1:0]  esel = 2'b01;
    logic        sirq = 1'b0, oen = 1'b1, owr = 1'b0, oval = 1'b0;
    logic        tout, irq;

    int checks = 0;
    int fails  = 0;
    int irq_seen = 0;
    bit done = 0;

    always #4 clk = ~clk;

    pin_freq_div u_dut (
        .clk(clk), .rst(rst), .tin_i(tin), .start_i(start), .stop_i(stop),
        .reload_i(reload), .edge_sel_i(esel), .start_irq_i(sirq),
        .out_en_i(oen), .out_wr_i(owr), .out_val_i(oval),
        .tout_o(tout), .irq_o(irq)
    );

    // behavioural reference model
    int  pin_hist[$];
    bit  m_run = 0, m_tout = 0, m_irq = 0;
    int  m_cnt = 0;

    always @(posedge clk) begin
        bit ev, cur, prv, fire;
        if (rst) begin
            m_run = 0; m_tout = 0; m_irq = 0; m_cnt = 0;
            pin_hist = '{0, 0, 0};
        end else begin
            prv = pin_hist[0][0];
            cur = pin_hist[1][0];
            case (esel)
                2'b00: ev = prv && !cur;
                2'b01: ev = cur && !prv;
                2'b10: ev = cur != prv;
                default: ev = 0;
            endcase
            fire = 0;
            if (start) begin
                m_run = 1; m_cnt = reload; fire = sirq;
            end else if (stop) begin
                m_run = 0;
            end else if (m_run && ev) begin
                if (m_cnt == 0) begin m_cnt = reload; fire = 1; end
                else m_cnt = m_cnt - 1;
            end
            m_irq = fire;
            if (oen) begin
                if (fire) m_tout = !m_tout;
            end else if (owr) m_tout = oval;
            void'(pin_hist.pop_front());
            pin_hist.push_back(int'(tin));
        end
    end

    task automatic chk(string req, int act, int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // per-cycle comparison, R4/R5
    always @(negedge clk) begin
        if (!rst && !done) begin
            chk("R4 irq vs model", int'(irq), int'(m_irq));
            chk("R5 tout vs model", int'(tout), int'(m_tout));
            if (irq) irq_seen++;
        end
    end

    task automatic cyc(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic pulses(int n);
        for (int i = 0; i < n; i++) begin
            tin = 1'b1; cyc(3);
            tin = 1'b0; cyc(3);
        end
        cyc(4);
    endtask

    task automatic do_start(logic also_stop);
        start = 1'b1; stop = also_stop; cyc(1);
        start = 1'b0; stop = 1'b0;
    endtask

    task automatic do_stop();
        stop = 1'b1; cyc(1); stop = 1'b0;
    endtask

    initial begin
        int base;
        bit t0;
        cyc(3);
        // R1: reset state
        chk("R1 tout after reset", int'(tout), 0);
        chk("R1 irq after reset", int'(irq), 0);
        rst = 1'b0; cyc(2);
        base = irq_seen;
        pulses(3);
        chk("R1 stopped after reset, no irq", irq_seen - base, 0);

        // R2/R4: rising, N=3, 8 edges -> 2 irq
        esel = 2'b01; reload = 16'd3; oen = 1'b1; sirq = 1'b0;
        do_start(1'b0); cyc(2);
        t0 = tout;
        base = irq_seen;
        pulses(4);
        chk("R5 toggle after N+1 edges", int'(tout), int'(!t0));
        pulses(4);
        chk("R4 rising N=3 irq count", irq_seen - base, 2);
        chk("R5 period 2(N+1) edges", int'(tout), int'(t0));

        // R2: latency, pin sampled at k counted at k+2
        reload = 16'd0; do_start(1'b0); cyc(2);
        tin = 1'b1; cyc(1);
        chk("R2 no irq one cycle after pin change", int'(irq), 0);
        cyc(1);
        chk("R2 no irq two cycles after pin change", int'(irq), 0);
        cyc(1);
        chk("R2 irq on third cycle", int'(irq), 1);
        tin = 1'b0; cyc(4);

        // R2: falling, N=1, 8 edges -> 4 irq
        esel = 2'b00; reload = 16'd1; do_start(1'b0); cyc(2);
        base = irq_seen; pulses(8);
        chk("R2 falling N=1 irq count", irq_seen - base, 4);

        // R2: both edges, N=1, 4 pulses = 8 edges -> 4 irq
        esel = 2'b10; do_start(1'b0); cyc(2);
        base = irq_seen; pulses(4);
        chk("R2 both-edge N=1 irq count", irq_seen - base, 4);

        // R3: prohibited code counts nothing
        esel = 2'b11; reload = 16'd0; do_start(1'b0); cyc(2);
        base = irq_seen; t0 = tout; pulses(6);
        chk("R3 mode 11 irq count", irq_seen - base, 0);
        chk("R3 mode 11 tout held", int'(tout), int'(t0));

        // R6: start with interrupt
        esel = 2'b01; reload = 16'd5; sirq = 1'b1; t0 = tout;
        start = 1'b1; cyc(1); start = 1'b0;
        chk("R6 start irq", int'(irq), 1);
        chk("R6 start toggles output", int'(tout), int'(!t0));
        cyc(1);
        chk("R6 start irq lasts one clock", int'(irq), 0);
        sirq = 1'b0; t0 = tout;
        start = 1'b1; cyc(1); start = 1'b0;
        chk("R6 plain start no irq", int'(irq), 0);
        chk("R6 plain start no toggle", int'(tout), int'(t0));

        // R7: stop holds, restart reloads
        reload = 16'd2; do_start(1'b0); cyc(2);
        pulses(2);
        do_stop(); cyc(1);
        base = irq_seen; t0 = tout; pulses(5);
        chk("R7 stopped irq count", irq_seen - base, 0);
        chk("R7 stopped tout held", int'(tout), int'(t0));
        do_start(1'b0); cyc(2);
        base = irq_seen; pulses(2);
        chk("R7 restart reloads (no early expiry)", irq_seen - base, 0);
        pulses(1);
        chk("R7 restart expiry after N+1", irq_seen - base, 1);

        // R8: output gating and direct write
        oen = 1'b0; oval = 1'b1; owr = 1'b1; cyc(1); owr = 1'b0;
        chk("R8 direct write 1", int'(tout), 1);
        reload = 16'd0; sirq = 1'b1; do_start(1'b0); sirq = 1'b0; cyc(1);
        base = irq_seen; pulses(3);
        chk("R8 counting still interrupts", irq_seen - base, 3);
        chk("R8 counting leaves output", int'(tout), 1);
        oval = 1'b0; owr = 1'b1; cyc(1); owr = 1'b0;
        chk("R8 direct write 0", int'(tout), 0);
        oen = 1'b1; oval = 1'b1; owr = 1'b1; cyc(1); owr = 1'b0;
        chk("R8 write ignored when enabled", int'(tout), 0);

        // R9: start and stop together -> runs
        do_stop(); reload = 16'd1; do_start(1'b1); cyc(2);
        base = irq_seen; pulses(4);
        chk("R9 start wins over stop", irq_seen - base, 2);

        // R1: reset mid-run
        rst = 1'b1; cyc(2);
        chk("R1 tout cleared by reset", int'(tout), 0);
        chk("R1 irq cleared by reset", int'(irq), 0);
        rst = 1'b0; cyc(2);
        base = irq_seen; pulses(3);
        chk("R1 stopped after mid-run reset", irq_seen - base, 0);

        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        #1000000;
        if (!done) begin
            done = 1;
            checks++; fails++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

endmodule